// File: doc/BRIEF.md
# Queue-to-Channel Transmit Scheduler

This block decides which transmit queue sends its next descriptor, and to which transmit FIFO channel it goes. There are up to sixteen circular queues and up to seven FIFO channels. Software programs each queue with a target channel, an enable flag and a delivery mode: block-ack, where acknowledgement windows are tracked, or strict in-order FIFO. Several queues may point at the same channel. Each queue keeps a count of descriptors that are waiting. A doorbell pulse adds one to that count, and issuing a descriptor takes one away.

In every cycle the scheduler looks for eligible queues. A queue is eligible when it is enabled, has at least one descriptor waiting, and its target channel is not reporting full. Channels carry fixed priority, and the highest-numbered channel that has an eligible queue wins. Channels 0 to 3 are background, best effort, video and voice/management, so voice/management beats video, video beats best effort, and best effort beats background. Queues that share a channel take turns under a per-channel rotating pointer. The chosen queue index, its channel and its mode are presented with a valid/ready handshake toward the FIFO side.

Top module: `txq_sched`

## Requirements
- R1: After reset `out_valid` is low, every queue is disabled with channel 0 and FIFO mode, and every descriptor count is zero, so no grant appears until a queue is both enabled and rung.
- R2: A cycle with `cfg_we` high stores `cfg_chan`, `cfg_active` and `cfg_blockack` for queue `cfg_queue`, and descriptor counts are left unchanged. A grant reports the stored mode on `out_blockack` (1 = block-ack, 0 = in-order FIFO).
- R3: A `db_valid` cycle adds one to the count of queue `db_queue`. The count saturates at 2^CNT_W-1, and further doorbells to a full count are ignored.
- R4: A queue is eligible only if it is active, its count is nonzero, and its channel number is below NCH with the matching bit of `fifo_full` low. A channel number of NCH or above never gets a grant.
- R5: When several channels have eligible queues, the grant goes to the highest-numbered channel.
- R6: Among eligible queues on one channel, the search starts at the queue after that channel's last winner and wraps modulo NQ. After reset the search starts at queue 0.
- R7: While `out_valid` is high and `out_ready` is low, `out_queue`, `out_chan` and `out_blockack` hold, and changes to `fifo_full` do not withdraw the grant. When `out_ready` is high, a new grant may load in the same cycle.
- R8: Loading a grant takes one from that queue's count. A doorbell to the same queue in the same cycle leaves the count unchanged.
- R9: Any number of queues may map to one channel, and `out_chan` always equals the channel configured for `out_queue` when the grant was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_queue | input | $clog2(NQ) | Queue being configured |
| cfg_chan | input | 3 | Target FIFO channel |
| cfg_active | input | 1 | Queue enable |
| cfg_blockack | input | 1 | Mode: 1 block-ack, 0 in-order FIFO |
| db_valid | input | 1 | Doorbell: one new descriptor |
| db_queue | input | $clog2(NQ) | Queue rung by the doorbell |
| fifo_full | input | NCH | Per-channel full flags |
| out_valid | output | 1 | Grant present |
| out_ready | input | 1 | FIFO side accepts the grant |
| out_queue | output | $clog2(NQ) | Granted queue |
| out_chan | output | 3 | Channel of the grant |
| out_blockack | output | 1 | Mode of the granted queue |

## Verification
The bench keeps a behavioural model of counts, pointers and the held grant, and compares it with the design every cycle. It drives several phases: doorbells to disabled queues, a full drain of a mixed map in which nine extra queues share channels 0 to 3, a long pseudo-random sweep of stalls, full flags, doorbells and reconfiguration, counter saturation, and a queue aimed at a nonexistent channel. If the channel priority is inverted, the drain order comes out wrong. A pointer that fails to advance starves the queues after the first one on a shared channel. A grant that is dropped or altered under stall breaks R7. A counter that wraps at saturation loses every descriptor after 255, so the drain ends early.

// File: rtl/txq_sched_pkg.sv
// Shared types for the transmit queue scheduler.
// Assumes channel numbers fit in CHAN_W bits and at most 2**CHAN_W-1 channels exist.
package txq_sched_pkg;
    localparam int unsigned CHAN_W = 3;

    typedef struct packed {
        logic              active;
        logic              blockack;
        logic [CHAN_W-1:0] chan;
    } qcfg_t;
endpackage

// File: rtl/txq_sched_qstate.sv
// Per-queue configuration registers and descriptor counters.
// Assumes at most one config write, one doorbell and one grant per cycle.
module txq_sched_qstate
    import txq_sched_pkg::*;
#(
    parameter int unsigned NQ    = 16,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned QW    = $clog2(NQ)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [QW-1:0]         cfg_queue,
    input  logic [CHAN_W-1:0]     cfg_chan,
    input  logic                  cfg_active,
    input  logic                  cfg_blockack,
    input  logic                  db_valid,
    input  logic [QW-1:0]         db_queue,
    input  logic                  take,
    input  logic [QW-1:0]         take_queue,
    output qcfg_t [NQ-1:0]        qcfg,
    output logic  [NQ-1:0]        cnt_nz
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar q = 0; q < NQ; q++) begin : g_q
        qcfg_t            cfg_r;
        logic [CNT_W-1:0] cnt_r;
        logic             inc;
        logic             dec;

        // Doorbell and issue strobes for this queue; doorbell blocked at saturation.
        always_comb begin
            inc = db_valid && (db_queue == QW'(q)) && (cnt_r != CNT_MAX);
            dec = take && (take_queue == QW'(q));
        end

        // Configuration and count registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_r <= '0;
                cnt_r <= '0;
            end else begin
                if (cfg_we && (cfg_queue == QW'(q))) begin
                    cfg_r.active   <= cfg_active;
                    cfg_r.blockack <= cfg_blockack;
                    cfg_r.chan     <= cfg_chan;
                end
                cnt_r <= cnt_r + CNT_W'(inc) - CNT_W'(dec);
            end
        end

        assign qcfg[q]   = cfg_r;
        assign cnt_nz[q] = (cnt_r != '0);
    end
endmodule

// File: rtl/txq_sched_rr.sv
// Round-robin picker for one channel: first requester after the last winner.
// Assumes adv is only raised with adv_queue taken from this picker's own result.
module txq_sched_rr #(
    parameter int unsigned NQ = 16,
    parameter int unsigned QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] req,
    input  logic          adv,
    input  logic [QW-1:0] adv_queue,
    output logic          hit,
    output logic [QW-1:0] pick
);
    logic [QW-1:0] ptr_r;

    // Scan from farthest to nearest so the nearest requester after ptr_r wins.
    always_comb begin
        int unsigned s;
        hit  = 1'b0;
        pick = '0;
        for (int i = NQ; i >= 1; i--) begin
            s = int'(ptr_r) + i;
            if (s >= NQ) s = s - NQ;
            if (req[s]) begin
                hit  = 1'b1;
                pick = QW'(s);
            end
        end
    end

    // Pointer remembers the last winner; reset makes queue 0 first in line.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_r <= QW'(NQ - 1);
        else if (adv) ptr_r <= adv_queue;
    end
endmodule

// File: rtl/txq_sched.sv
// Transmit scheduler top: eligibility, per-channel round robin,
// fixed channel priority (highest number wins) and a held valid/ready output.
// Assumes NCH <= 2**CHAN_W - 1 so an out-of-range channel number exists and is padded full.
module txq_sched
    import txq_sched_pkg::*;
#(
    parameter int unsigned NQ    = 16,
    parameter int unsigned NCH   = 7,
    parameter int unsigned CNT_W = 8,
    parameter int unsigned QW    = $clog2(NQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QW-1:0]     cfg_queue,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic              cfg_active,
    input  logic              cfg_blockack,
    input  logic              db_valid,
    input  logic [QW-1:0]     db_queue,
    input  logic [NCH-1:0]    fifo_full,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [QW-1:0]     out_queue,
    output logic [CHAN_W-1:0] out_chan,
    output logic              out_blockack
);
    localparam int unsigned NSLOT = 2 ** CHAN_W;
    localparam int unsigned NPAD  = NSLOT - NCH;

    qcfg_t [NQ-1:0]          qcfg;
    logic  [NQ-1:0]          cnt_nz;
    logic  [NQ-1:0]          elig;
    logic  [NSLOT-1:0]       full_pad;
    logic  [NCH-1:0][NQ-1:0] req_c;
    logic  [NCH-1:0]         hit_c;
    logic  [NCH-1:0][QW-1:0] pick_c;
    logic                    win_hit;
    logic  [CHAN_W-1:0]      win_ch;
    logic  [QW-1:0]          win_q;
    logic                    take;

    txq_sched_qstate #(.NQ(NQ), .CNT_W(CNT_W), .QW(QW)) u_qstate (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_queue(cfg_queue), .cfg_chan(cfg_chan),
        .cfg_active(cfg_active), .cfg_blockack(cfg_blockack),
        .db_valid(db_valid), .db_queue(db_queue),
        .take(take), .take_queue(win_q),
        .qcfg(qcfg), .cnt_nz(cnt_nz)
    );

    // Nonexistent channels look permanently full.
    assign full_pad = {{NPAD{1'b1}}, fifo_full};

    for (genvar q = 0; q < NQ; q++) begin : g_elig
        assign elig[q] = qcfg[q].active && cnt_nz[q] && !full_pad[qcfg[q].chan];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar q = 0; q < NQ; q++) begin : g_req
            assign req_c[c][q] = elig[q] && (qcfg[q].chan == CHAN_W'(c));
        end
        txq_sched_rr #(.NQ(NQ), .QW(QW)) u_rr (
            .clk(clk), .rst_n(rst_n),
            .req(req_c[c]),
            .adv(take && (win_ch == CHAN_W'(c))),
            .adv_queue(win_q),
            .hit(hit_c[c]), .pick(pick_c[c])
        );
    end

    // Fixed priority across channels: later (higher) channels override.
    always_comb begin
        win_hit = 1'b0;
        win_ch  = '0;
        win_q   = '0;
        for (int c = 0; c < NCH; c++) begin
            if (hit_c[c]) begin
                win_hit = 1'b1;
                win_ch  = CHAN_W'(c);
                win_q   = pick_c[c];
            end
        end
    end

    // A new grant loads when the output slot is free or being accepted.
    assign take = win_hit && (!out_valid || out_ready);

    // Output grant register, held until accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_queue    <= '0;
            out_chan     <= '0;
            out_blockack <= 1'b0;
        end else if (take) begin
            out_valid    <= 1'b1;
            out_queue    <= win_q;
            out_chan     <= win_ch;
            out_blockack <= qcfg[win_q].blockack;
        end else if (out_ready) begin
            out_valid    <= 1'b0;
        end
    end
endmodule

// File: rtl/txq_sched_chk.sv
// Port-level protocol checks for txq_sched, attached by bind.
// Assumes the same parameters as the bound instance.
module txq_sched_chk
    import txq_sched_pkg::*;
#(
    parameter int unsigned NQ  = 16,
    parameter int unsigned NCH = 7,
    parameter int unsigned QW  = $clog2(NQ)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              db_valid,
    input logic [NCH-1:0]    fifo_full,
    input logic              out_valid,
    input logic              out_ready,
    input logic [QW-1:0]     out_queue,
    input logic [CHAN_W-1:0] out_chan,
    input logic              out_blockack
);
    logic [NCH-1:0] prev_full;
    logic           seen_db;

    // Remember last cycle's full flags and whether any doorbell has arrived.
    always_ff @(posedge clk) begin
        prev_full <= fifo_full;
        if (!rst_n)        seen_db <= 1'b0;
        else if (db_valid) seen_db <= 1'b1;
    end

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_queue)
                                    && $stable(out_chan) && $stable(out_blockack));

    a_r4_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_chan) < NCH));

    a_r4_not_full_at_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> !prev_full[out_chan]);

    a_r1_no_grant_before_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seen_db);
endmodule

bind txq_sched txq_sched_chk #(.NQ(NQ), .NCH(NCH), .QW(QW)) u_chk (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .fifo_full(fifo_full),
    .out_valid(out_valid), .out_ready(out_ready), .out_queue(out_queue),
    .out_chan(out_chan), .out_blockack(out_blockack)
);

// File: tb/txq_sched_tb.sv
module txq_sched_tb;
    localparam int NQ = 16;
    localparam int NCH = 7;
    localparam int CNT_W = 8;
    localparam int QW = 4;
    localparam int CMAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_active = 0, cfg_blockack = 0;
    logic [QW-1:0] cfg_queue = '0;
    logic [2:0] cfg_chan = '0;
    logic db_valid = 0;
    logic [QW-1:0] db_queue = '0;
    logic [NCH-1:0] fifo_full = '0;
    logic out_ready = 0;
    logic out_valid, out_blockack;
    logic [QW-1:0] out_queue;
    logic [2:0] out_chan;

    int n_tests = 0, n_fail = 0, cycles = 0, grants = 0;
    bit done = 0;

    // model state
    int m_cnt[NQ]; bit m_act[NQ]; int m_ch[NQ]; bit m_ba[NQ]; int m_ptr[NCH];
    bit m_v; int m_q, m_c; bit m_b;

    always #10 clk = ~clk;

    txq_sched #(.NQ(NQ), .NCH(NCH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_queue(cfg_queue),
        .cfg_chan(cfg_chan), .cfg_active(cfg_active), .cfg_blockack(cfg_blockack),
        .db_valid(db_valid), .db_queue(db_queue), .fifo_full(fifo_full),
        .out_valid(out_valid), .out_ready(out_ready), .out_queue(out_queue),
        .out_chan(out_chan), .out_blockack(out_blockack)
    );

    task automatic model_reset();
        for (int q = 0; q < NQ; q++) begin
            m_cnt[q] = 0; m_act[q] = 0; m_ch[q] = 0; m_ba[q] = 0;
        end
        for (int c = 0; c < NCH; c++) m_ptr[c] = NQ - 1;
        m_v = 0; m_q = 0; m_c = 0; m_b = 0;
    endtask

    function automatic bit elig(int q);
        return m_act[q] && m_cnt[q] != 0 && m_ch[q] < NCH && !fifo_full[m_ch[q]];
    endfunction

    // Advance model one cycle from current inputs (R4, R5, R6, R8, R2, R3).
    task automatic model_step();
        int pq, pc, cq, q;
        bit ld;
        pq = -1; pc = 0;
        for (int c = 0; c < NCH; c++) begin
            cq = -1;
            for (int i = NQ; i >= 1; i--) begin
                q = (m_ptr[c] + i) % NQ;
                if (elig(q) && m_ch[q] == c) cq = q;
            end
            if (cq >= 0) begin pq = cq; pc = c; end
        end
        ld = (pq >= 0) && (!m_v || out_ready);
        if (db_valid && m_cnt[db_queue] != CMAX) m_cnt[db_queue]++;
        if (ld) begin
            m_cnt[pq]--; m_ptr[pc] = pq;
            m_v = 1; m_q = pq; m_c = pc; m_b = m_ba[pq];
        end else if (out_ready) m_v = 0;
        if (cfg_we) begin
            m_act[cfg_queue] = cfg_active; m_ch[cfg_queue] = cfg_chan;
            m_ba[cfg_queue] = cfg_blockack;
        end
    endtask

    task automatic check(string tag);
        n_tests++;
        if (out_valid !== m_v ||
            (m_v && (out_queue !== QW'(m_q) || out_chan !== 3'(m_c) || out_blockack !== m_b))) begin
            n_fail++;
            $display("FAIL %s: got v=%0b q=%0d ch=%0d ba=%0b, expected v=%0b q=%0d ch=%0d ba=%0b",
                     tag, out_valid, out_queue, out_chan, out_blockack, m_v, m_q, m_c, m_b);
        end
    endtask

    // One cycle: model, edge, compare at negedge, then clear strobes.
    task automatic step(string tag);
        if (out_valid && out_ready) grants++;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag);
        cfg_we = 0; db_valid = 0;
    endtask

    task automatic cfg(int q, int ch, bit act, bit ba, string tag);
        cfg_we = 1; cfg_queue = QW'(q); cfg_chan = 3'(ch);
        cfg_active = act; cfg_blockack = ba;
        step(tag);
    endtask

    task automatic ring(int q, string tag);
        db_valid = 1; db_queue = QW'(q);
        step(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog: an expired run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected under 150000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] lfsr;
        int g;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1 reset");
        cfg(0, 0, 1, 0, "R1 enable without doorbell");
        for (int i = 0; i < 4; i++) step("R1 idle counts zero");

        // R4: doorbells to disabled queues produce nothing
        out_ready = 1;
        cfg(0, 0, 0, 0, "R4 disable");
        for (int q = 0; q < NQ; q++) begin ring(q, "R4 inactive"); ring(q, "R4 inactive"); end
        for (int i = 0; i < 4; i++) step("R4 inactive idle");

        // R2/R9/R5/R6: queues 0..6 direct, 7..15 shared on channels 0..3 in block-ack
        for (int q = 0; q < NQ; q++)
            cfg(q, (q < 7) ? q : q % 4, 1, q >= 7, "R2 config");
        for (int i = 0; i < 2 * NQ + 6; i++) step("R5 R6 R9 drain");

        // R7/R8: pseudo-random sweep of stalls, full flags, doorbells, reconfig
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = lfsr[0] | lfsr[1];
            fifo_full = (lfsr[5:2] == 4'h0) ? NCH'(lfsr[12:6]) : '0;
            db_valid = lfsr[3] | lfsr[9];
            db_queue = lfsr[15:12];
            if (lfsr[11:4] == 8'h5A) begin
                cfg_we = 1; cfg_queue = lfsr[7:4]; cfg_chan = lfsr[10:8] % 7;
                cfg_active = 1; cfg_blockack = lfsr[2];
            end
            step("R7 R8 sweep");
        end
        fifo_full = '0; out_ready = 1;
        for (int i = 0; i < 1200; i++) step("R8 sweep drain");

        // R3: saturation, only queue 5 active and blocked while ringing 300 times
        for (int q = 0; q < NQ; q++) cfg(q, 0, 0, 0, "R3 clear");
        cfg(5, 2, 1, 1, "R3 setup");
        fifo_full = 7'b0000100;
        for (int i = 0; i < 300; i++) ring(5, "R3 saturate");
        fifo_full = '0;
        grants = 0;
        for (int i = 0; i < 300; i++) step("R3 drain");
        g = grants;
        n_tests++;
        if (g != CMAX) begin
            n_fail++;
            $display("FAIL R3 saturated drain: got %0d grants, expected %0d", g, CMAX);
        end

        // R4: channel number beyond NCH is never granted
        cfg(5, 7, 1, 0, "R4 bad channel");
        ring(5, "R4 bad channel");
        for (int i = 0; i < 5; i++) step("R4 bad channel idle");

        finish_run();
    end
endmodule